// File: doc/BRIEF.md
# Serial Configuration Flash Slave Model

This block is a synthesizable stand-in for a serial NOR flash that holds an FPGA bitstream. It sits on a four-wire SPI bus in mode 0 (serial clock idles low). The serial clock, select and data lines are sampled by a faster system clock. Each command starts with a one-byte opcode. The model has a status register with block protection, and write, program and erase commands are accepted only after a write-enable. Program and erase are carried out during a busy period, and software polls that period through the status register.

The storage is a small register array of 2^MEM_AW bytes. Sector, subsector and page sizes are exponents given as parameters, so the defaults are scaled down. Setting SECT_AW to 16 gives the real 64 KiB sector. Address bits above the array width are ignored. Reset leaves the array erased, so every byte reads FFh.

Top module: `cfg_flash_model`

## Requirements
- R1: Read (03h) takes a 3-byte address, MSB first. It returns bytes from that address on MISO, which changes after the falling edge of the serial clock. The address auto-increments and wraps from the last byte of the array to byte 0.
- R2: Fast read (0Bh) adds exactly 8 dummy clocks (one byte) after the address, and then returns data the same way as read.
- R3: Read status (05h) returns the status byte, and repeats it for as long as select stays low. Bit 0 is busy. Bit 1 is write-enable. Bits 4:2 are the protect level P2..P0. Bit 5 is the bottom-select flag. Bits 7 and 6 always read 0.
- R4: Write enable (06h) sets status bit 1, and write disable (04h) clears it.
- R5: Write status (01h) plus one data byte copies data bits 5:2 into the status register and starts a busy period, but only when write-enable is set. Data bits 7:6 are dropped. Without write-enable the command has no effect.
- R6: Page program (02h) takes an address followed by data bytes. It is committed when select rises on a byte boundary after at least one data byte. Each target byte becomes old AND new. Data wraps within a page of 2^PAGE_AW bytes.
- R7: Sector erase (D8h) sets to FFh every byte of the 2^SECT_AW-byte sector that holds the address. Subsector erase (20h) does the same for the 2^SUB_AW-byte subsector.
- R8: Bulk erase (C7h) sets the whole array to FFh.
- R9: While busy is 1, every opcode other than 05h is ignored and MISO returns 0. Busy lasts one clock per byte written, plus BUSY_CYCLES clocks.
- R10: Write-enable clears by itself when the busy period ends.
- R11: Raising select in the middle of a command aborts it. An incomplete program or erase does not start, and write-enable stays set.
- R12: The protect level n selects 2^(n-1) sectors: level 0 protects nothing and level 7 protects everything. These sectors are at the top of the array when bit 5 is 0 and at the bottom when it is 1. Program or erase aimed at a protected sector is dropped without starting a busy period, and write-enable is cleared. Bulk erase is dropped whenever the level is not 0.
- R13: Read ID (9Fh) returns the three bytes of ID_WORD, high byte first, and then zeros.
- R14: After reset the status reads 00h, every byte reads FFh, and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data into the model |
| miso | output | 1 | Serial data out of the model |

## Verification
The bench targets these corner cases:
- A read that crosses the end of the array, which a wrong design would continue into undefined bytes instead of wrapping to 0.
- A program that starts near the end of a page, where a wrong design would spill into the next page.
- A program whose last byte is cut short, which a design that commits on the fly would partly write.
- Commands sent during a long erase, where a design without busy gating would clear write-enable or return array data.
- Protected programs and erases at both the top and the bottom of the array, where a wrong design would alter the memory or leave write-enable set.

// File: rtl/cfg_flash_model.sv
module cfg_flash_model #(
  parameter int MEM_AW      = 10,
  parameter int SECT_AW     = 8,
  parameter int SUB_AW      = 6,
  parameter int PAGE_AW     = 4,
  parameter int BUSY_CYCLES = 64,
  parameter logic [23:0] ID_WORD = 24'h20BA18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int MEM_BYTES  = 1 << MEM_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int NSECT      = 1 << (MEM_AW - SECT_AW);
  localparam int DLY_W      = $clog2(BUSY_CYCLES + 2);
  localparam logic [MEM_AW-1:0] SECT_MSK = ~MEM_AW'((1 << SECT_AW) - 1);
  localparam logic [MEM_AW-1:0] SUB_MSK  = ~MEM_AW'((1 << SUB_AW) - 1);
  localparam logic [MEM_AW-1:0] PAGE_MSK = ~MEM_AW'((1 << PAGE_AW) - 1);

  localparam logic [7:0] OP_WRSR = 8'h01, OP_PP = 8'h02, OP_READ = 8'h03, OP_WRDI = 8'h04,
                         OP_RDSR = 8'h05, OP_WREN = 8'h06, OP_FAST = 8'h0B, OP_RDID = 8'h9F,
                         OP_BE = 8'hC7, OP_SE = 8'hD8, OP_SSE = 8'h20;

  function automatic logic op_known(input logic [7:0] o);
    case (o)
      OP_WRSR, OP_PP, OP_READ, OP_WRDI, OP_RDSR, OP_WREN,
      OP_FAST, OP_RDID, OP_BE, OP_SE, OP_SSE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic in_prot(input logic [MEM_AW-1:0] a, input logic [2:0] lvl,
                                   input logic bot);
    int s, cnt;
    s = int'(a >> SECT_AW);
    if (lvl == 3'd0) return 1'b0;
    if (lvl == 3'd7) return 1'b1;
    cnt = 1 << (int'(lvl) - 1);
    if (cnt >= NSECT) return 1'b1;
    return bot ? (s < cnt) : (s >= NSECT - cnt);
  endfunction

  logic s_sck, s_cs, s_mosi, sck_d, cs_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s_sck, s_cs, s_mosi, sck_d, cs_d} <= 5'b01001;
    else        {s_sck, s_cs, s_mosi, sck_d, cs_d} <= {sck, cs_n, mosi, s_sck, s_cs};

  wire rise  = s_sck & ~sck_d & ~s_cs;
  wire fall  = ~s_sck & sck_d & ~s_cs;
  wire cs_up = s_cs & ~cs_d;

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [6:0] sh;
  logic [2:0] bitn, bcnt;
  logic [7:0] op, tx;
  logic ign;
  logic [MEM_AW-1:0] adr, rptr;
  logic [PAGE_AW-1:0] pofs;
  logic wip, wel, tb;
  logic [2:0] bp;
  logic [MEM_AW:0] wrem;
  logic [MEM_AW-1:0] wptr;
  logic wprog;
  logic [DLY_W-1:0] dly;

  wire [7:0] nb = {sh, s_mosi};
  wire byte_done = rise && (bitn == 3'd7);
  wire [MEM_AW-1:0] a_now = MEM_AW'({adr, nb});
  wire new_ign = (wip && nb != OP_RDSR) || !op_known(nb);
  wire [7:0] cur_op = (bcnt == 3'd0) ? nb : op;
  wire cur_ign = (bcnt == 3'd0) ? new_ign : ign;
  wire [7:0] status = {2'b00, tb, bp, wel, wip};
  wire [MEM_AW-1:0] rd_a = (bcnt == 3'd3) ? a_now : rptr;
  wire load_mem = !cur_ign && ((cur_op == OP_READ && bcnt >= 3'd3) ||
                               (cur_op == OP_FAST && bcnt >= 3'd4));
  wire pp_data = byte_done && op == OP_PP && !ign && bcnt >= 3'd4;

  logic [7:0] next_tx;
  always_comb begin
    next_tx = 8'h00;
    if (load_mem) next_tx = mem[rd_a];
    else if (!cur_ign && cur_op == OP_RDSR) next_tx = status;
    else if (!cur_ign && cur_op == OP_RDID)
      case (bcnt)
        3'd0: next_tx = ID_WORD[23:16];
        3'd1: next_tx = ID_WORD[15:8];
        3'd2: next_tx = ID_WORD[7:0];
        default: next_tx = 8'h00;
      endcase
  end

  logic hit, prot, prog, st_go, st_rej;
  logic [MEM_AW-1:0] base;
  logic [MEM_AW:0] len;
  always_comb begin
    hit = 1'b0; prot = 1'b0; prog = 1'b0; base = '0; len = '0;
    case (op)
      OP_PP:  begin hit = bcnt >= 3'd5; prog = 1'b1; base = adr & PAGE_MSK;
                    len = (MEM_AW+1)'(PAGE_BYTES); prot = in_prot(adr, bp, tb); end
      OP_SE:  begin hit = bcnt == 3'd4; base = adr & SECT_MSK;
                    len = (MEM_AW+1)'(1 << SECT_AW); prot = in_prot(adr, bp, tb); end
      OP_SSE: begin hit = bcnt == 3'd4; base = adr & SUB_MSK;
                    len = (MEM_AW+1)'(1 << SUB_AW); prot = in_prot(adr, bp, tb); end
      OP_BE:  begin hit = bcnt == 3'd1; len = (MEM_AW+1)'(MEM_BYTES); prot = bp != 3'd0; end
      default: ;
    endcase
    hit    = hit && cs_up && bitn == 3'd0 && !ign && wel && !wip;
    st_go  = hit && !prot;
    st_rej = hit && prot;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; bitn <= '0; bcnt <= '0; op <= '0; ign <= 1'b0; tx <= '0; miso <= 1'b0;
      adr <= '0; rptr <= '0; pofs <= '0; pmask <= '0;
    end else if (s_cs) begin
      bitn <= '0; bcnt <= '0; ign <= 1'b0; tx <= '0; miso <= 1'b0;
    end else begin
      if (rise) begin sh <= nb[6:0]; bitn <= bitn + 3'd1; end
      if (byte_done) begin
        if (bcnt != 3'd7) bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd0) begin
          op <= nb; ign <= new_ign;
          if (nb == OP_PP && !new_ign) pmask <= '0;
        end
        if (bcnt >= 3'd1 && bcnt <= 3'd3) adr <= a_now;
        if (bcnt == 3'd3) begin pofs <= a_now[PAGE_AW-1:0]; rptr <= a_now; end
        if (load_mem) rptr <= rd_a + 1'b1;
        if (pp_data) begin pmask[pofs] <= 1'b1; pofs <= pofs + 1'b1; end
        tx <= next_tx;
      end
      if (fall) begin miso <= tx[7]; tx <= {tx[6:0], 1'b0}; end
    end

  always_ff @(posedge clk)
    if (pp_data) pbuf[pofs] <= nb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wip <= 1'b0; wel <= 1'b0; bp <= '0; tb <= 1'b0;
      wrem <= '0; wptr <= '0; wprog <= 1'b0; dly <= '0;
    end else begin
      if (byte_done && bcnt == 3'd0 && !new_ign) begin
        if (nb == OP_WREN) wel <= 1'b1;
        if (nb == OP_WRDI) wel <= 1'b0;
      end
      if (byte_done && bcnt == 3'd1 && op == OP_WRSR && !ign && wel) begin
        bp <= nb[4:2]; tb <= nb[5];
        wip <= 1'b1; wrem <= '0; wprog <= 1'b0; dly <= DLY_W'(BUSY_CYCLES);
      end
      if (st_go) begin
        wip <= 1'b1; wptr <= base; wrem <= len; wprog <= prog; dly <= DLY_W'(BUSY_CYCLES);
      end
      if (st_rej) wel <= 1'b0;
      if (wip) begin
        if (wrem != '0) begin wptr <= wptr + 1'b1; wrem <= wrem - 1'b1; end
        else if (dly != '0) dly <= dly - 1'b1;
        else begin wip <= 1'b0; wel <= 1'b0; end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wip && wrem != '0) begin
      if (!wprog) mem[wptr] <= 8'hFF;
      else if (pmask[wptr[PAGE_AW-1:0]]) mem[wptr] <= mem[wptr] & pbuf[wptr[PAGE_AW-1:0]];
    end

  // R10
  wel_autoclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  // R5
  busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> wel);
  // R9
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> $stable({tb, bp}));
  // R14
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs && cs_d) |-> !miso);
endmodule

// File: tb/cfg_flash_model_tb.sv
module cfg_flash_model_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int MEM_AW = 10;
  localparam int NB = 1 << MEM_AW;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_flash_model #(.MEM_AW(MEM_AW), .SECT_AW(8), .SUB_AW(6), .PAGE_AW(4),
                    .BUSY_CYCLES(600), .ID_WORD(24'h20BA18)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int checks = 0, errors = 0;
  logic [7:0] model [NB];
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic cap = 1'b0;
  int rx_n = 0;
  logic [7:0] rx_sh = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(posedge sck) if (cap) begin
    rx_sh = {rx_sh[6:0], miso};
    rx_n++;
    if (rx_n == 8) begin
      rx_n = 0;
      if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", rx_sh, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rx_sh === e, t, rx_sh, e);
      end
    end
  end

  task automatic sbits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      r = {r[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sb(input logic [7:0] b);
    logic [7:0] r;
    sbits(b, 8, r);
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (2) @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
  endtask

  task automatic simple(input logic [7:0] o);
    cs_lo(); sb(o); cs_hi();
  endtask

  task automatic addr3(input int a);
    sb(8'(a >> 16)); sb(8'(a >> 8)); sb(8'(a));
  endtask

  task automatic cap_bytes(input int n);
    cap = 1'b1;
    for (int i = 0; i < n; i++) sb(8'h00);
    cap = 1'b0;
  endtask

  task automatic rd(input logic [7:0] o, input int a, input int n, input bit zero, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(zero ? 8'h00 : model[(a + i) % NB]);
      tag_q.push_back(tag);
    end
    cs_lo(); sb(o); addr3(a);
    if (o == 8'h0B) sb(8'h00);
    cap_bytes(n); cs_hi();
  endtask

  task automatic rdsr(input logic [7:0] e, input int n, input string tag);
    for (int i = 0; i < n; i++) begin exp_q.push_back(e); tag_q.push_back(tag); end
    cs_lo(); sb(8'h05); cap_bytes(n); cs_hi();
  endtask

  task automatic poll();
    logic [7:0] r;
    for (int k = 0; k < 400; k++) begin
      cs_lo(); sb(8'h05); sbits(8'h00, 8, r); cs_hi();
      if (!r[0]) return;
    end
    chk(1'b0, "R9 busy never ended", r, 8'h00);
  endtask

  task automatic prog(input int a, input logic [7:0] d [$], input bit ok);
    simple(8'h06);
    cs_lo(); sb(8'h02); addr3(a);
    foreach (d[i]) sb(d[i]);
    cs_hi();
    poll();
    if (ok) foreach (d[i]) begin
      int t;
      t = (a & ~15) | ((a + i) & 15);
      model[t] = model[t] & d[i];
    end
  endtask

  task automatic erase(input logic [7:0] o, input int a, input bit ok);
    int sz;
    simple(8'h06);
    cs_lo(); sb(o); if (o != 8'hC7) addr3(a); cs_hi();
    poll();
    sz = (o == 8'hD8) ? 256 : (o == 8'h20) ? 64 : NB;
    if (ok) for (int i = 0; i < NB; i++) if ((i & ~(sz - 1)) == ((a % NB) & ~(sz - 1))) model[i] = 8'hFF;
  endtask

  task automatic wrsr(input logic [7:0] v);
    simple(8'h06);
    cs_lo(); sb(8'h01); sb(v); cs_hi();
    poll();
  endtask

  task automatic report();
    if (exp_q.size() != 0) chk(1'b0, "scoreboard-left", 8'(exp_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 8'h00, 8'h00);
      report();
    end
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R14: idle output and erased contents after reset
    chk(miso === 1'b0, "R14 miso after reset", {7'd0, miso}, 8'h00);
    rdsr(8'h00, 2, "R14 R3 reset status");
    rd(8'h03, 16'h03FE, 4, 0, "R1 R14 wrap read");
    // R4
    simple(8'h06); rdsr(8'h02, 1, "R4 wren");
    simple(8'h04); rdsr(8'h00, 1, "R4 wrdi");
    // R6: no program without write-enable
    cs_lo(); sb(8'h02); addr3(16'h0010); sb(8'h00); cs_hi();
    rdsr(8'h00, 1, "R6 gated program status");
    rd(8'h03, 16'h0010, 1, 0, "R6 gated program data");
    // R6 R9 R10: page wrap, busy visible
    simple(8'h06);
    cs_lo(); sb(8'h02); addr3(16'h001E);
    sb(8'hA1); sb(8'hB2); sb(8'hC3); sb(8'hD4); cs_hi();
    rdsr(8'h03, 1, "R9 busy during program");
    poll();
    for (int i = 0; i < 4; i++) begin
      int t;
      t = 16'h0010 | ((16'h1E + i) & 15);
      model[t] = model[t] & (i == 0 ? 8'hA1 : i == 1 ? 8'hB2 : i == 2 ? 8'hC3 : 8'hD4);
    end
    rdsr(8'h00, 1, "R10 wel cleared after program");
    rd(8'h03, 16'h0010, 16, 0, "R6 page wrap");
    prog(16'h0010, '{8'h0F}, 1);
    rd(8'h03, 16'h0010, 2, 0, "R6 and-program");
    // R2
    rd(8'h0B, 16'h001E, 4, 0, "R2 fast read");
    // R13
    exp_q.push_back(8'h20); exp_q.push_back(8'hBA); exp_q.push_back(8'h18); exp_q.push_back(8'h00);
    repeat (4) tag_q.push_back("R13 id");
    cs_lo(); sb(8'h9F); cap_bytes(4); cs_hi();
    // R11: cut program leaves wel, no change
    simple(8'h06);
    cs_lo(); sb(8'h02); addr3(16'h0040); sbits(8'h00, 4, r); cs_hi();
    rdsr(8'h02, 1, "R11 partial program keeps wel");
    rd(8'h03, 16'h0040, 1, 0, "R11 partial program no write");
    cs_lo(); sb(8'hD8); sb(8'h00); cs_hi();
    rdsr(8'h02, 1, "R11 short erase not started");
    simple(8'h04);
    // R9 R7: commands ignored during sector erase
    simple(8'h06);
    cs_lo(); sb(8'hD8); addr3(16'h0015); cs_hi();
    simple(8'h04);
    rdsr(8'h03, 1, "R9 wrdi ignored while busy");
    rd(8'h03, 16'h0010, 2, 1, "R9 read ignored while busy");
    poll();
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    rdsr(8'h00, 1, "R10 wel cleared after erase");
    rd(8'h03, 16'h001E, 2, 0, "R7 sector erased");
    // R7 subsector
    prog(16'h0150, '{8'h11, 8'h22}, 1);
    prog(16'h0180, '{8'h33}, 1);
    erase(8'h20, 16'h0150, 1);
    rd(8'h03, 16'h0150, 2, 0, "R7 subsector erased");
    rd(8'h03, 16'h0180, 1, 0, "R7 neighbour kept");
    // R5
    cs_lo(); sb(8'h01); sb(8'h3C); cs_hi();
    rdsr(8'h00, 1, "R5 write status without wel");
    wrsr(8'h44);
    rdsr(8'h04, 1, "R5 reserved bit dropped");
    // R12 top protection
    prog(16'h0300, '{8'h00}, 0);
    rdsr(8'h04, 1, "R12 protected program clears wel");
    rd(8'h03, 16'h0300, 1, 0, "R12 protected program no write");
    erase(8'hD8, 16'h0380, 0);
    rdsr(8'h04, 1, "R12 protected erase");
    erase(8'hC7, 0, 0);
    rd(8'h03, 16'h0180, 1, 0, "R12 bulk rejected");
    // R12 bottom protection
    wrsr(8'h24);
    rdsr(8'h24, 1, "R5 bottom flag");
    prog(16'h0000, '{8'h55}, 0);
    prog(16'h0300, '{8'h5A}, 1);
    rd(8'h03, 16'h0000, 1, 0, "R12 bottom protected");
    rd(8'h03, 16'h0300, 1, 0, "R12 top open");
    // R8
    wrsr(8'h00);
    erase(8'hC7, 0, 1);
    rd(8'h03, 16'h0300, 1, 0, "R8 bulk erase");
    rd(8'h03, 16'h0180, 1, 0, "R8 bulk erase");
    rdsr(8'h00, 1, "R8 idle after bulk");
    done = 1;
    report();
  end
endmodule